// File: doc/BRIEF.md
# Instruction Realignment Queue

This block decouples instruction fetch from instruction execution. A fetch side walks forward through memory one aligned 32-bit word at a time, issuing requests on an instruction bus, and drops every returned word, tagged with its word address and a bus-error bit, into a small queue. An issue side reads the queue and hands the execute stage one whole instruction per transfer. Instructions come in two lengths: 16-bit compressed and 32-bit. A 32-bit instruction may begin in the upper half of one word and end in the lower half of the next. Compressed half-words are passed on unexpanded, zero-extended, with a flag set.

Fetching continues while execution stalls, until the queue is full. A redirect input throws away everything queued and restarts fetching at a new address. The same applies to a fence request, which also sends a one-cycle pulse to the memory side so that any instruction cache can resynchronise. When compressed support is disabled by parameter, every word is one instruction. A redirect to an address with bit 1 set then produces a single misalignment report instead of a fetch.

The instruction bus request side uses valid/ready. Address and valid stay stable until ready is seen. At most one request is outstanding. Responses come back in order as a single-cycle valid with no ready, exactly one per accepted request.

On the issue side, `iss_valid_o` does not depend on `iss_ready_i`. A transfer happens on a rising edge where both are high. While ready is low the offered instruction is held.

Top module: `ifetch_realign`

## Requirements
- R1: While `iss_valid_o` is high and `iss_ready_i` is low, the offered instruction, its address and its flags stay unchanged until the transfer or a redirect. Instructions are issued in program order, one per transfer.
- R2: A half-word whose low two bits are 11 starts a 32-bit instruction, which is issued with `iss_compressed_o` low. Any other value is a 16-bit instruction, issued in bits 15:0 with bits 31:16 zero and `iss_compressed_o` high.
- R3: After an instruction at address A, the next one is at A+2 for a compressed instruction and A+4 otherwise. A 32-bit instruction at an address with bit 1 set is formed from that word's upper half (bits 15:0 of the result) and the next word's lower half (bits 31:16).
- R4: A 32-bit instruction starting in the upper half of a word is offered only once the following word is also queued.
- R5: A redirect empties the queue and drops any response still outstanding from before it. It restarts fetching at the word holding the target, and the next issued instruction carries the target address. During the redirect cycle and the cycle after it, `iss_valid_o` is low.
- R6: A fence request acts as a redirect to `redir_pc_i`. It also raises `fence_pulse_o` for exactly the one cycle after the request cycle.
- R7: Bit 0 of every issued address is zero, even when a redirect target is odd.
- R8: With compressed support disabled, every queued word is issued as one 32-bit instruction. A redirect to an address with bit 1 set issues one entry with `iss_misalign_o` high at that address and then nothing more until the next redirect.
- R9: `iss_bus_err_o` is high exactly when some word covered by the issued instruction was returned with `ibus_rsp_err_i` high.
- R10: While issue is stalled, the fetch side accepts exactly DEPTH requests after a redirect and then keeps `ibus_req_valid_o` low. The queue never overflows or underflows.
- R11: During and right after reset, `iss_valid_o` and `fence_pulse_o` are low, and the first fetch and first issue are at RESET_PC.
- R12: An instruction bus request that is not accepted keeps its address and stays valid until accepted, unless a redirect or fence intervenes. Request addresses are word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid_i | input | 1 | Discard queued instructions and restart at `redir_pc_i` |
| redir_pc_i | input | 32 | Restart address for redirect and fence |
| fence_req_i | input | 1 | Fence request: restart plus memory-side pulse |
| fence_pulse_o | output | 1 | One-cycle pulse to the memory side after a fence request |
| ibus_req_valid_o | output | 1 | Fetch request valid |
| ibus_req_ready_i | input | 1 | Fetch request accepted |
| ibus_req_addr_o | output | 32 | Word-aligned fetch address |
| ibus_rsp_valid_i | input | 1 | Fetch data returned (one per accepted request) |
| ibus_rsp_data_i | input | 32 | Returned instruction word |
| ibus_rsp_err_i | input | 1 | Returned word had a bus error |
| iss_valid_o | output | 1 | An instruction is offered |
| iss_ready_i | input | 1 | Execute side takes the offered instruction |
| iss_insn_o | output | 32 | Instruction bits (compressed: zero-extended half-word) |
| iss_pc_o | output | 32 | Address of the offered instruction |
| iss_compressed_o | output | 1 | Offered instruction is 16 bits |
| iss_bus_err_o | output | 1 | Offered instruction touched a word that returned an error |
| iss_misalign_o | output | 1 | Misaligned-target report (compressed support disabled) |

## Verification
The bench builds two copies with DEPTH 4 and RESET_PC 0: one with compressed support and one without, both driven by the same redirect, fence and ready inputs. Memory is a hashed half-word pattern, so each run walks a dense, irregular mix of 16-bit instructions, aligned 32-bit instructions and word-straddling 32-bit instructions. One word is marked as a bus error, which brings erroring straddles within reach. The bus adds a random acceptance delay and a response latency of one to four cycles, and the execute side applies random back-pressure. Redirects therefore land on outstanding responses. With only four queue entries, a full-queue stall is reached within a few cycles. The disabled-compression copy exercises the misalignment report and the plain one-word-per-instruction stream.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  localparam int unsigned XW = 32;

  typedef struct packed {
    logic [XW-1:2] wa;    // word address of the fetched chunk
    logic [XW-1:0] data;  // fetched instruction bits
    logic          err;   // bus error on this fetch
    logic          mis;   // misaligned-target marker, no data
  } fq_entry_t;
endpackage

// File: rtl/ifr_queue.sv
module ifr_queue
  import ifr_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       push_i,
  input  fq_entry_t                  push_ent_i,
  input  logic                       pop_i,
  output fq_entry_t                  head_o,
  output logic [15:0]                next_lo_o,
  output logic                       next_err_o,
  output logic [$clog2(DEPTH):0]     level_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  fq_entry_t         slots [DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     lvl_q;
  fq_entry_t         nxt;

  always_ff @(posedge clk) begin
    if (push_i) slots[wp_q] <= push_ent_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + PW'(1);
      if (pop_i)  rp_q <= rp_q + PW'(1);
      lvl_q <= lvl_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o     = slots[rp_q];
  assign nxt        = slots[rp_q + PW'(1)];
  assign next_lo_o  = nxt.data[15:0];
  assign next_err_o = nxt.err;
  assign level_o    = lvl_q;

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clr_i) |-> (lvl_q != CW'(DEPTH)));
  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !clr_i) |-> (lvl_q != '0));
endmodule

// File: rtl/ifr_fetch.sv
module ifr_fetch
  import ifr_pkg::*;
#(
  parameter logic [31:0] RESET_PC   = 32'h0,
  parameter bit          COMPRESSED = 1'b1,
  parameter int unsigned DEPTH      = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   kill_i,
  input  logic [31:1]            kill_pc_i,
  input  logic [$clog2(DEPTH):0] level_i,
  output logic                   req_valid_o,
  input  logic                   req_ready_i,
  output logic [31:0]            req_addr_o,
  input  logic                   rsp_valid_i,
  input  logic [31:0]            rsp_data_i,
  input  logic                   rsp_err_i,
  output logic                   push_o,
  output fq_entry_t              push_ent_o
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  typedef enum logic [1:0] {F_RUN, F_TRAP, F_HALT} fstate_t;

  fstate_t       st_q;
  logic [31:2]   fa_q, pa_q;
  logic          busy_q, stale_q;
  logic          accept;

  assign req_valid_o = (st_q == F_RUN) && !busy_q && (level_i < CW'(DEPTH)) && !kill_i;
  assign req_addr_o  = {fa_q, 2'b00};
  assign accept      = req_valid_o && req_ready_i;

  always_comb begin
    push_o = !kill_i && ((rsp_valid_i && busy_q && !stale_q) || (st_q == F_TRAP));
    if (st_q == F_TRAP) begin
      push_ent_o.wa   = fa_q;
      push_ent_o.data = '0;
      push_ent_o.err  = 1'b0;
      push_ent_o.mis  = 1'b1;
    end else begin
      push_ent_o.wa   = pa_q;
      push_ent_o.data = rsp_data_i;
      push_ent_o.err  = rsp_err_i;
      push_ent_o.mis  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= F_RUN;
      fa_q    <= RESET_PC[31:2];
      pa_q    <= RESET_PC[31:2];
      busy_q  <= 1'b0;
      stale_q <= 1'b0;
    end else if (kill_i) begin
      fa_q    <= kill_pc_i[31:2];
      busy_q  <= busy_q && !rsp_valid_i;
      stale_q <= busy_q && !rsp_valid_i;
      st_q    <= (!COMPRESSED && kill_pc_i[1]) ? F_TRAP : F_RUN;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        pa_q   <= fa_q;
        fa_q   <= fa_q + 30'd1;
      end
      if (rsp_valid_i && busy_q) begin
        busy_q  <= 1'b0;
        stale_q <= 1'b0;
      end
      if (st_q == F_TRAP) st_q <= F_HALT;
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (kill_i || (req_valid_o && $stable(req_addr_o))));
  // R12
  req_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_addr_o[1:0] == 2'b00));
endmodule

// File: rtl/ifr_issue.sv
module ifr_issue
  import ifr_pkg::*;
#(
  parameter logic [31:0] RESET_PC   = 32'h0,
  parameter bit          COMPRESSED = 1'b1,
  parameter int unsigned DEPTH      = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   kill_i,
  input  logic                   kill_half_i,
  input  fq_entry_t              head_i,
  input  logic [15:0]            next_lo_i,
  input  logic                   next_err_i,
  input  logic [$clog2(DEPTH):0] level_i,
  output logic                   pop_o,
  output logic                   iss_valid_o,
  input  logic                   iss_ready_i,
  output logic [31:0]            iss_insn_o,
  output logic [31:0]            iss_pc_o,
  output logic                   iss_compressed_o,
  output logic                   iss_bus_err_o,
  output logic                   iss_misalign_o
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic        half_q, half_d;
  logic        vld, adv, fire;
  logic [15:0] lo, hi;

  always_comb begin
    vld              = 1'b0;
    adv              = 1'b0;
    half_d           = half_q;
    iss_insn_o       = '0;
    iss_compressed_o = 1'b0;
    iss_bus_err_o    = 1'b0;
    iss_misalign_o   = 1'b0;
    lo               = head_i.data[15:0];
    hi               = head_i.data[31:16];
    if (level_i != '0) begin
      if (head_i.mis) begin
        vld            = 1'b1;
        adv            = 1'b1;
        half_d         = 1'b0;
        iss_misalign_o = 1'b1;
      end else if (!half_q) begin
        vld           = 1'b1;
        iss_bus_err_o = head_i.err;
        if (COMPRESSED && lo[1:0] != 2'b11) begin
          iss_insn_o       = {16'h0, lo};
          iss_compressed_o = 1'b1;
          half_d           = 1'b1;
        end else begin
          iss_insn_o = head_i.data;
          adv        = 1'b1;
        end
      end else if (hi[1:0] != 2'b11) begin
        vld              = 1'b1;
        adv              = 1'b1;
        half_d           = 1'b0;
        iss_insn_o       = {16'h0, hi};
        iss_compressed_o = 1'b1;
        iss_bus_err_o    = head_i.err;
      end else if (level_i >= CW'(2)) begin
        vld           = 1'b1;
        adv           = 1'b1;
        iss_insn_o    = {next_lo_i, hi};
        iss_bus_err_o = head_i.err | next_err_i;
      end
    end
  end

  assign iss_valid_o = vld && !kill_i;
  assign iss_pc_o    = {head_i.wa, half_q, 1'b0};
  assign fire        = iss_valid_o && iss_ready_i;
  assign pop_o       = fire && adv;

  always_ff @(posedge clk) begin
    if (!rst_n)      half_q <= RESET_PC[1];
    else if (kill_i) half_q <= kill_half_i;
    else if (fire)   half_q <= half_d;
  end

  // R1
  issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid_o && !iss_ready_i) |=> (kill_i || (iss_valid_o && $stable(iss_insn_o)
                                       && $stable(iss_pc_o) && $stable(iss_bus_err_o))));
  // R4
  straddle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid_o && !iss_compressed_o && !iss_misalign_o && iss_pc_o[1]) |-> (level_i >= CW'(2)));
  // R8
  plain_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!COMPRESSED && iss_valid_o && !iss_misalign_o) |-> (!iss_pc_o[1] && !iss_compressed_o));
endmodule

// File: rtl/ifetch_realign.sv
module ifetch_realign
  import ifr_pkg::*;
#(
  parameter logic [31:0] RESET_PC   = 32'h0,
  parameter bit          COMPRESSED = 1'b1,
  parameter int unsigned DEPTH      = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        redir_valid_i,
  input  logic [31:0] redir_pc_i,
  input  logic        fence_req_i,
  output logic        fence_pulse_o,
  output logic        ibus_req_valid_o,
  input  logic        ibus_req_ready_i,
  output logic [31:0] ibus_req_addr_o,
  input  logic        ibus_rsp_valid_i,
  input  logic [31:0] ibus_rsp_data_i,
  input  logic        ibus_rsp_err_i,
  output logic        iss_valid_o,
  input  logic        iss_ready_i,
  output logic [31:0] iss_insn_o,
  output logic [31:0] iss_pc_o,
  output logic        iss_compressed_o,
  output logic        iss_bus_err_o,
  output logic        iss_misalign_o
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic            kill, push, pop, next_err, fence_q;
  fq_entry_t       push_ent, head;
  logic [15:0]     next_lo;
  logic [CW-1:0]   level;

  assign kill = redir_valid_i || fence_req_i;

  ifr_fetch #(.RESET_PC(RESET_PC), .COMPRESSED(COMPRESSED), .DEPTH(DEPTH)) fetch_u (
    .clk(clk), .rst_n(rst_n), .kill_i(kill), .kill_pc_i(redir_pc_i[31:1]),
    .level_i(level), .req_valid_o(ibus_req_valid_o), .req_ready_i(ibus_req_ready_i),
    .req_addr_o(ibus_req_addr_o), .rsp_valid_i(ibus_rsp_valid_i),
    .rsp_data_i(ibus_rsp_data_i), .rsp_err_i(ibus_rsp_err_i),
    .push_o(push), .push_ent_o(push_ent)
  );

  ifr_queue #(.DEPTH(DEPTH)) queue_u (
    .clk(clk), .rst_n(rst_n), .clr_i(kill), .push_i(push), .push_ent_i(push_ent),
    .pop_i(pop), .head_o(head), .next_lo_o(next_lo), .next_err_o(next_err),
    .level_o(level)
  );

  ifr_issue #(.RESET_PC(RESET_PC), .COMPRESSED(COMPRESSED), .DEPTH(DEPTH)) issue_u (
    .clk(clk), .rst_n(rst_n), .kill_i(kill), .kill_half_i(redir_pc_i[1]),
    .head_i(head), .next_lo_i(next_lo), .next_err_i(next_err), .level_i(level),
    .pop_o(pop), .iss_valid_o(iss_valid_o), .iss_ready_i(iss_ready_i),
    .iss_insn_o(iss_insn_o), .iss_pc_o(iss_pc_o), .iss_compressed_o(iss_compressed_o),
    .iss_bus_err_o(iss_bus_err_o), .iss_misalign_o(iss_misalign_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fence_q <= 1'b0;
    else        fence_q <= fence_req_i;
  end
  assign fence_pulse_o = fence_q;

  // R6
  fence_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req_i |=> fence_pulse_o);
  // R6
  fence_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fence_req_i) |=> !fence_pulse_o);
  // R5
  redirect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !iss_valid_o);
endmodule

// File: tb/ifetch_realign_tb_top.sv
module ifr_bus_model #(
  parameter logic [31:0] ERR_ADDR = 32'h94,
  parameter logic [15:0] SEED     = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        rsp_err
);
  logic [15:0] lfsr;
  logic        busy;
  logic [1:0]  cnt;
  logic [31:0] addr;

  function automatic logic [15:0] hw(input logic [31:0] a);
    logic [31:0] x;
    x = (a >> 1) * 32'd2654435761;
    return x[31:16] ^ x[15:0];
  endfunction

  assign req_ready = !busy && lfsr[0];
  assign rsp_valid = busy && (cnt == 2'd0);
  assign rsp_data  = {hw({addr[31:2], 2'b10}), hw({addr[31:2], 2'b00})};
  assign rsp_err   = ({addr[31:2], 2'b00} == ERR_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= SEED; busy <= 1'b0; cnt <= '0; addr <= '0;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (req_valid && req_ready) begin
        busy <= 1'b1; cnt <= lfsr[2:1]; addr <= req_addr;
      end else if (busy) begin
        if (cnt == 2'd0) busy <= 1'b0;
        else             cnt  <= cnt - 2'd1;
      end
    end
  end
endmodule

module ifetch_realign_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          DEPTH      = 4;
  localparam logic [31:0] ERR_ADDR   = 32'h94;
  localparam int          WD_LIMIT   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic redir = 1'b0, fence = 1'b0, rdy = 1'b0;
  logic [31:0] tgt = '0;
  int vectors = 0, fails = 0, cyc = 0, acc = 0;
  logic [31:0] exp_pc = '0;
  bit sel = 1'b0, took = 1'b0;

  logic c_fp, c_rv, c_rr, c_sv, c_se, c_v, c_cm, c_be, c_mi;
  logic [31:0] c_ra, c_sd, c_in, c_pc;
  logic n_fp, n_rv, n_rr, n_sv, n_se, n_v, n_cm, n_be, n_mi;
  logic [31:0] n_ra, n_sd, n_in, n_pc;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ifetch_realign #(.RESET_PC(32'h0), .COMPRESSED(1'b1), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .redir_valid_i(redir), .redir_pc_i(tgt), .fence_req_i(fence),
    .fence_pulse_o(c_fp), .ibus_req_valid_o(c_rv), .ibus_req_ready_i(c_rr),
    .ibus_req_addr_o(c_ra), .ibus_rsp_valid_i(c_sv), .ibus_rsp_data_i(c_sd),
    .ibus_rsp_err_i(c_se), .iss_valid_o(c_v), .iss_ready_i(rdy), .iss_insn_o(c_in),
    .iss_pc_o(c_pc), .iss_compressed_o(c_cm), .iss_bus_err_o(c_be), .iss_misalign_o(c_mi));
  ifr_bus_model #(.ERR_ADDR(ERR_ADDR), .SEED(16'hACE1)) bus_c (
    .clk(clk), .rst_n(rst_n), .req_valid(c_rv), .req_addr(c_ra), .req_ready(c_rr),
    .rsp_valid(c_sv), .rsp_data(c_sd), .rsp_err(c_se));

  ifetch_realign #(.RESET_PC(32'h0), .COMPRESSED(1'b0), .DEPTH(DEPTH)) dut_nc_i (
    .clk(clk), .rst_n(rst_n), .redir_valid_i(redir), .redir_pc_i(tgt), .fence_req_i(fence),
    .fence_pulse_o(n_fp), .ibus_req_valid_o(n_rv), .ibus_req_ready_i(n_rr),
    .ibus_req_addr_o(n_ra), .ibus_rsp_valid_i(n_sv), .ibus_rsp_data_i(n_sd),
    .ibus_rsp_err_i(n_se), .iss_valid_o(n_v), .iss_ready_i(rdy), .iss_insn_o(n_in),
    .iss_pc_o(n_pc), .iss_compressed_o(n_cm), .iss_bus_err_o(n_be), .iss_misalign_o(n_mi));
  ifr_bus_model #(.ERR_ADDR(ERR_ADDR), .SEED(16'h5EED)) bus_n (
    .clk(clk), .rst_n(rst_n), .req_valid(n_rv), .req_addr(n_ra), .req_ready(n_rr),
    .rsp_valid(n_sv), .rsp_data(n_sd), .rsp_err(n_se));

  logic        o_v, o_cm, o_be, o_mi;
  logic [31:0] o_in, o_pc;
  assign o_v  = sel ? n_v  : c_v;
  assign o_cm = sel ? n_cm : c_cm;
  assign o_be = sel ? n_be : c_be;
  assign o_mi = sel ? n_mi : c_mi;
  assign o_in = sel ? n_in : c_in;
  assign o_pc = sel ? n_pc : c_pc;

  function automatic logic [15:0] hw(input logic [31:0] a);
    logic [31:0] x;
    x = (a >> 1) * 32'd2654435761;
    return x[31:16] ^ x[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2 R3 R7 R9: compare the issued instruction against the walk over memory
  task automatic check_issue(input bit use_c);
    logic [15:0] lo;
    logic [31:0] ei;
    bit cm, er;
    lo = hw(exp_pc);
    if (!use_c && exp_pc[1]) begin
      chk(o_mi == 1'b1 && o_pc == exp_pc, "R8 misalign report", {31'h0, o_mi, o_pc}, {32'h1, exp_pc});
      return;
    end
    cm = use_c && (lo[1:0] != 2'b11);
    ei = cm ? {16'h0, lo} : {hw(exp_pc + 32'd2), lo};
    er = ({exp_pc[31:2], 2'b00} == ERR_ADDR) ||
         (!cm && ({exp_pc[31:2] + 30'd1, 2'b00} == ERR_ADDR) && exp_pc[1]);
    chk(o_pc == exp_pc && o_pc[0] == 1'b0, "R3/R7 issue address", {32'h0, o_pc}, {32'h0, exp_pc});
    chk(o_in == ei && o_cm == cm && o_mi == 1'b0, "R2 instruction bits/length",
        {o_cm, 31'h0, o_in}, {cm, 31'h0, ei});
    chk(o_be == er, "R9 bus error flag", {63'h0, o_be}, {63'h0, er});
    exp_pc = exp_pc + (cm ? 32'd2 : 32'd4);
  endtask

  task automatic step(input bit use_c, input bit rand_rdy);
    @(negedge clk);
    rdy = rand_rdy ? (($urandom % 4) != 0) : 1'b1;
    #1;
    took = o_v && rdy;
    if (took) check_issue(use_c);
  endtask

  task automatic run(input int n, input bit use_c);
    int got;
    got = 0;
    while (got < n) begin
      step(use_c, 1'b1);
      if (took) got++;
    end
  endtask

  task automatic restart(input logic [31:0] t, input bit fl);
    @(negedge clk);
    rdy = 1'b0; tgt = t;
    if (fl) fence = 1'b1; else redir = 1'b1;
    @(negedge clk);
    redir = 1'b0; fence = 1'b0;
    exp_pc = {t[31:1], 1'b0};
    #1;
    acc = (c_rv && c_rr) ? 1 : 0;
    // R5: queue emptied, nothing offered right after the restart
    chk(o_v == 1'b0, "R5 valid low after restart", {63'h0, o_v}, 64'h0);
    if (fl) begin
      // R6: pulse present in the cycle after the request
      chk(c_fp == 1'b1, "R6 fence pulse high", {63'h0, c_fp}, 64'h1);
      @(negedge clk); #1;
      if (c_rv && c_rr) acc++;
      chk(c_fp == 1'b0, "R6 fence pulse single cycle", {63'h0, c_fp}, 64'h0);
    end
  endtask

  initial begin
    wait (cyc >= WD_LIMIT);
    fails++;
    $display("FAIL R1 watchdog expired: cycles=%0d expected below %0d", cyc, WD_LIMIT);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int quiet;
    repeat (4) @(negedge clk);
    #1;
    // R11: quiet during reset
    chk(c_v == 1'b0 && c_fp == 1'b0, "R11 reset outputs", {62'h0, c_v, c_fp}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(c_v == 1'b0, "R11 valid low after reset", {63'h0, c_v}, 64'h0);
    exp_pc = 32'h0;
    run(160, 1'b1);                      // R11 first issue at RESET_PC, R1 R2 R3 R4 R9
    restart(32'h0000_0046, 1'b0); run(100, 1'b1);   // R5 target in upper half
    restart(32'h0000_0081, 1'b0); run(60, 1'b1);    // R7 odd target
    restart(32'h0000_0092, 1'b0); run(30, 1'b1);    // R9 straddle into error word
    // R10: stalled issue, exactly DEPTH words fetched ahead
    restart(32'h0000_0130, 1'b0);
    repeat (60) begin
      @(negedge clk); #1;
      if (c_rv && c_rr) acc++;
    end
    chk(acc == DEPTH && c_rv == 1'b0, "R10 fetch-ahead limit", {31'h0, c_rv, 32'(acc)}, {32'h0, 32'(DEPTH)});
    run(50, 1'b1);
    restart(32'h0000_0012, 1'b1); run(50, 1'b1);    // R6 fence restarts like a redirect
    // R8: compression disabled copy
    sel = 1'b1;
    restart(32'h0000_0200, 1'b0); run(40, 1'b0);
    restart(32'h0000_0102, 1'b0); run(1, 1'b0);
    quiet = 0;
    repeat (20) begin
      @(negedge clk); rdy = 1'b1; #1;
      if (n_v) quiet++;
    end
    chk(quiet == 0, "R8 silent after misalign", 64'(quiet), 64'h0);
    restart(32'h0000_0090, 1'b0); run(20, 1'b0);    // R8 R9 plain words incl. error word
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule